// File: doc/BRIEF.md
# Hierarchical Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned operands of width `W` (32 by default) and returns their full-width `2W`-bit product. It is purely combinational: there is no clock, no register and no handshake, so the product follows the operands within one settling time. It fits inside an arithmetic unit wherever a single-cycle multiply is needed.

The product is built by recursive quartering. A `W`-bit multiply splits each operand into a high and a low half. Four half-width multipliers then form the low-by-low, low-by-high, high-by-low and high-by-high sub-products. The recursion ends at a 2x2 cell. That cell takes its lowest bit from the vertical AND of the two least significant bits. It takes the next bit from a half adder over the two crosswise ANDs. A second half adder folds the crosswise carry into the AND of the two upper bits, and gives the top two bits.

At each level, the lowest `W/2` bits of the low-by-low sub-product go straight to the output. The remaining sub-products are merged in two steps. A carry-save row of full adders reduces the three aligned terms to two. A truncating ripple adder then resolves those two terms. `W` must be a power of two no smaller than 2, and elaboration stops if it is not.

Top module: `vxm_mult`

## Requirements
- R1: `p` equals the unsigned product of `a` and `b`, zero-extended to `2W` bits, for every pair of operand values.
- R2: The lowest product bit is `a[0] & b[0]`, and bit 1 is `(a[1]&b[0]) ^ (a[0]&b[1])`. For operands below 4, the product is `{c2,s2,s1,s0}`, where `s1` and carry `k` come from the half add of the two crosswise terms, and `s2`/`c2` are the sum and carry of `a[1]&b[1]` plus `k`.
- R3: All-ones operands give a product whose upper `W` bits are all ones except bit 0 of that half, and whose lower `W` bits equal 1. For `W`=32, that is 0xFFFFFFFE00000001.
- R4: If either operand is zero, the product is zero.
- R5: If one operand is 1, the product equals the other operand zero-extended.
- R6: If `a` is `2^k` for `k` in 0..W-1, the product is `b` shifted left by `k`, and the same holds with the roles of `a` and `b` swapped.
- R7: The product depends only on the present operands. It settles with no clock edge, and a repeated operand pair gives the same product whatever was applied before it.
- R8: When both operands are below `2^(W/2)`, the upper `W` bits of the product are zero.
- R9: When the low `W/2` bits of both operands are zero, the lower `W` bits of the product are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | Unsigned multiplicand |
| b | input | W | Unsigned multiplier |
| p | output | 2W | Unsigned full-width product |

## Verification
The assertions are evaluated whenever the operands settle. They cover the exact product against the arithmetic operator, the vertical and crosswise low bits, zero and unit operands, the all-ones corner, and the zero halves for narrow or low-cleared operands. Only the bench scenarios can cover the rest. These are the shift behaviour for every power-of-two position, the settling of the product between clock edges, and the history independence of a repeated operand pair. The bench also sweeps all sixteen 2-bit operand pairs against the half-adder formula of the base cell.

// File: rtl/vxm_pkg.sv
package vxm_pkg;

   // Width at which the recursion stops and the 2x2 cell is used.
   localparam int unsigned BASE_W = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic bit width_ok(input int unsigned v);
      return is_pow2(v) && (v >= BASE_W);
   endfunction

endpackage

// File: rtl/vxm_half_add.sv
module vxm_half_add (
   input  logic x,
   input  logic y,
   output logic s,
   output logic c
);
   assign s = x ^ y;
   assign c = x & y;
endmodule

// File: rtl/vxm_full_add.sv
module vxm_full_add (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   logic xy;
   assign xy = x ^ y;
   assign s  = xy ^ ci;
   assign co = (x & y) | (xy & ci);
endmodule

// File: rtl/vxm_cell2.sv
// 2x2 base cell: one vertical AND, two crosswise ANDs folded by a half adder,
// and a second half adder merging the crosswise carry into the top AND.
module vxm_cell2 (
   input  logic [1:0] x,
   input  logic [1:0] y,
   output logic [3:0] z
);
   logic g00, g10, g01, g11;
   logic s1, k, s2, c2;

   assign g00 = x[0] & y[0];
   assign g10 = x[1] & y[0];
   assign g01 = x[0] & y[1];
   assign g11 = x[1] & y[1];

   vxm_half_add u_cross (
      .x (g10),
      .y (g01),
      .s (s1),
      .c (k)
   );

   vxm_half_add u_upper (
      .x (g11),
      .y (k),
      .s (s2),
      .c (c2)
   );

   assign z = {c2, s2, s1, g00};
endmodule

// File: rtl/vxm_trunc_add.sv
// Ripple adder whose carry out of the top bit is never formed: callers
// guarantee the true sum fits in WIDTH bits.
module vxm_trunc_add #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] s
);
   logic [WIDTH-1:0] cy;

   assign cy[0] = cin;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i < WIDTH - 1) begin : g_fa
         vxm_full_add u_fa (
            .x  (x[i]),
            .y  (y[i]),
            .ci (cy[i]),
            .s  (s[i]),
            .co (cy[i+1])
         );
      end else begin : g_top
         assign s[i] = x[i] ^ y[i] ^ cy[i];
      end
   end
endmodule

// File: rtl/vxm_combine.sv
// Merges four S x S sub-products into one 4S-bit product:
//   ll + (lh + hl) << S + hh << 2S
// The lowest S bits of ll pass straight through; the upper 3S bits are
// reduced by a carry-save row and resolved by a truncating ripple adder.
module vxm_combine #(
   parameter int unsigned S = 2
) (
   input  logic [2*S-1:0] ll,
   input  logic [2*S-1:0] lh,
   input  logic [2*S-1:0] hl,
   input  logic [2*S-1:0] hh,
   output logic [4*S-1:0] p
);
   localparam int unsigned T = 3 * S;

   logic [T-1:0] opa, opb, opc;
   logic [T-1:0] sv, cv;
   logic [T-1:0] upper;

   assign opa = {hh, ll[2*S-1:S]};
   assign opb = {{S{1'b0}}, lh};
   assign opc = {{S{1'b0}}, hl};

   assign cv[0] = 1'b0;

   for (genvar i = 0; i < T; i++) begin : g_csa
      if (i < T - 1) begin : g_fa
         vxm_full_add u_fa (
            .x  (opa[i]),
            .y  (opb[i]),
            .ci (opc[i]),
            .s  (sv[i]),
            .co (cv[i+1])
         );
      end else begin : g_top
         assign sv[i] = opa[i] ^ opb[i] ^ opc[i];
      end
   end

   vxm_trunc_add #(.WIDTH(T)) u_final (
      .x   (sv),
      .y   (cv),
      .cin (1'b0),
      .s   (upper)
   );

   assign p = {upper, ll[S-1:0]};
endmodule

// File: rtl/vxm_node.sv
// One level of the recursion: a W x W multiply built from four W/2 sub-nodes,
// or the 2x2 cell when W reaches the base width.
module vxm_node
   import vxm_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);
   if (W == BASE_W) begin : g_leaf
      vxm_cell2 u_cell (
         .x (a),
         .y (b),
         .z (p)
      );
   end else begin : g_split
      localparam int unsigned H = W / 2;

      logic [2*H-1:0] ll, lh, hl, hh;

      vxm_node #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(ll));
      vxm_node #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(lh));
      vxm_node #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(hl));
      vxm_node #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(hh));

      vxm_combine #(.S(H)) u_comb (
         .ll (ll),
         .lh (lh),
         .hl (hl),
         .hh (hh),
         .p  (p)
      );
   end
endmodule

// File: rtl/vxm_mult.sv
module vxm_mult
   import vxm_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);
   if (!width_ok(W)) begin : g_bad_width
      $error("vxm_mult: W must be a power of two and at least 2");
   end

   vxm_node #(.W(W)) u_root (
      .a (a),
      .b (b),
      .p (p)
   );
endmodule

// File: rtl/vxm_mult_chk.sv
module vxm_mult_chk #(
   parameter int unsigned W = 32
) (
   input logic [W-1:0]   a,
   input logic [W-1:0]   b,
   input logic [2*W-1:0] p
);
   localparam int unsigned H = W / 2;

   logic [2*W-1:0] wide_ref;
   logic [2*W-1:0] ones_ref;

   always_comb begin
      wide_ref = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      ones_ref = {{(W-1){1'b1}}, 1'b0, {(W-1){1'b0}}, 1'b1};
      if (!$isunknown({a, b, p})) begin
         AST_PRODUCT_EXACT: assert (p == wide_ref);                                   // R1
         AST_VERTICAL_BIT: assert (p[0] == (a[0] & b[0]));                            // R2
         AST_CROSS_BIT: assert (p[1] == ((a[1] & b[0]) ^ (a[0] & b[1])));             // R2
         AST_ALL_ONES: assert (!((&a) && (&b)) || (p == ones_ref));                  // R3
         AST_ZERO_ANNIHILATES: assert (!((a == '0) || (b == '0)) || (p == '0));      // R4
         AST_UNIT_IDENTITY: assert (!(a == W'(1)) || (p == {{W{1'b0}}, b}));         // R5
         AST_NARROW_UPPER_ZERO: assert (!((a[W-1:H] == '0) && (b[W-1:H] == '0)) || (p[2*W-1:W] == '0)); // R8
         AST_HIGH_LOWER_ZERO: assert (!((a[H-1:0] == '0) && (b[H-1:0] == '0)) || (p[W-1:0] == '0));     // R9
      end
   end
endmodule

bind vxm_mult vxm_mult_chk #(.W(W)) u_chk (
   .a (a),
   .b (b),
   .p (p)
);

// File: tb/vxm_mult_tb.sv
module vxm_mult_tb;
   localparam int  W          = 32;
   localparam time CLK_PERIOD = 10;
   localparam int  NRAND      = 3000;

   typedef struct {
      logic [W-1:0] x;
      logic [W-1:0] y;
      int           kind;   // 1 plain, 2 cell, 3 ones, 4 zero, 5 unit, 6 shift, 8 narrow, 9 high
      int           sh;
   } vec_t;

   logic           clk = 1'b0;
   logic           rst;
   logic [W-1:0]   a, b;
   logic [2*W-1:0] p;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;
   vec_t q[$];

   vxm_mult #(.W(W)) u_dut (.a(a), .b(b), .p(p));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
      logic [2*W-1:0] wx, wy;
      wx = {{W{1'b0}}, x};
      wy = {{W{1'b0}}, y};
      return wx * wy;
   endfunction

   task automatic check(input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s a=%h b=%h actual %h expected %h", tag, a, b, act, exp);
      end
   endtask

   task automatic push(input logic [W-1:0] x, input logic [W-1:0] y, input int kind, input int sh);
      vec_t v;
      v.x = x; v.y = y; v.kind = kind; v.sh = sh;
      q.push_back(v);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [2*W-1:0] first_seen;
      logic [1:0] a2, b2;
      logic s1, k, s2, c2;
      logic [2*W-1:0] exp2;

      rst = 1'b1; a = '0; b = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R4 reset state", p, '0);
      rst = 1'b0;

      // R2: every 2-bit operand pair
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 4; j++)
            push(W'(i), W'(j), 2, 0);
      // R3
      push('1, '1, 3, 0);
      // R4 / R5
      for (int i = 0; i < 4; i++) begin
         push('0, $urandom, 4, 0);
         push($urandom, '0, 4, 0);
         push(W'(1), $urandom, 5, 0);
         push($urandom, W'(1), 5, 0);
      end
      push(W'(1), '1, 5, 0);
      // R6
      for (int k2 = 0; k2 < W; k2++) begin
         push(W'(1) << k2, $urandom, 6, k2);
         push('1, W'(1) << k2, 6, k2);
      end
      // R8 / R9
      push({16'h0, 16'hFFFF}, {16'h0, 16'hFFFF}, 8, 0);
      push({16'hFFFF, 16'h0}, {16'hFFFF, 16'h0}, 9, 0);
      for (int i = 0; i < 20; i++) begin
         push({16'h0, 16'($urandom)}, {16'h0, 16'($urandom)}, 8, 0);
         push({16'($urandom), 16'h0}, {16'($urandom), 16'h0}, 9, 0);
      end
      // R1: carries across half boundaries and random operands
      push(32'h0000FFFF, 32'hFFFF0000, 1, 0);
      push(32'h80000000, 32'h80000000, 1, 0);
      push(32'h7FFFFFFF, 32'hFFFFFFFF, 1, 0);
      push(32'hAAAAAAAA, 32'h55555555, 1, 0);
      for (int i = 0; i < NRAND; i++) push($urandom, $urandom, 1, 0);

      while (q.size() > 0) begin
         vec_t v;
         v = q.pop_front();
         @(posedge clk);
         a = v.x; b = v.y;
         @(negedge clk);
         check("R1 product", p, ref_mul(v.x, v.y));
         case (v.kind)
            2: begin
               a2 = v.x[1:0]; b2 = v.y[1:0];
               s1 = (a2[1] & b2[0]) ^ (a2[0] & b2[1]);
               k  = (a2[1] & b2[0]) & (a2[0] & b2[1]);
               s2 = (a2[1] & b2[1]) ^ k;
               c2 = (a2[1] & b2[1]) & k;
               exp2 = {{(2*W-4){1'b0}}, c2, s2, s1, a2[0] & b2[0]};
               check("R2 base cell", p, exp2);
            end
            3: check("R3 all ones", p, 64'hFFFFFFFE00000001);
            4: check("R4 zero operand", p, '0);
            5: check("R5 unit operand", p, (v.x == W'(1)) ? {{W{1'b0}}, v.y} : {{W{1'b0}}, v.x});
            6: check("R6 power of two", p,
                     (v.x == (W'(1) << v.sh)) ? ({{W{1'b0}}, v.y} << v.sh) : ({{W{1'b0}}, v.x} << v.sh));
            8: check("R8 upper half zero", {{W{1'b0}}, p[2*W-1:W]}, '0);
            9: check("R9 lower half zero", {{W{1'b0}}, p[W-1:0]}, '0);
            default: ;
         endcase
      end

      // R7: settles without a clock edge, and is independent of history
      @(negedge clk);
      a = 32'h12345678; b = 32'h9ABCDEF0;
      #1;
      check("R7 settles without edge", p, ref_mul(32'h12345678, 32'h9ABCDEF0));
      first_seen = p;
      a = 32'hFFFFFFFF; b = 32'h00000003;
      #1;
      check("R7 second pair", p, ref_mul(32'hFFFFFFFF, 32'h00000003));
      a = 32'h12345678; b = 32'h9ABCDEF0;
      #1;
      check("R7 repeated pair", p, first_seen);

      @(negedge clk);
      finish_run();
   end
endmodule